// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a 32-bit load/store processor in which every instruction takes several clock cycles. It reads the opcode and function fields of the instruction register, the equality result of the datapath comparator and the memory wait line. From these it drives the register enables, the multiplexer selects, the ALU operation code, the register-file write controls and the memory strobes for every cycle. The ALU, the register file, the memory and the datapath registers themselves sit outside the block.

Every instruction starts with the same two cycles. The fetch cycle reads the instruction word and advances the program counter by four. The decode cycle reads both source registers and computes a branch target in advance. After decode, the class of the instruction sets how many cycles remain. Branches and jumps finish in one execute cycle. ALU and shift operations, and stores, take two more cycles. Loads take three more. Any cycle that uses memory stays in place for as long as the wait line is high.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous reset puts the sequencer in the fetch state, so fetch controls appear on the first cycle after reset.
- R2: Fetch drives mem_rd=1, addr_sel=0 (PC), alu_a_sel=0 (PC), alu_b_sel=1 (constant 4) and alu_op=0 (ADD). When mem_wait is low it also drives ir_en=1 and pc_en=1 with pc_src=0 (ALU result) and moves to decode. When mem_wait is high it keeps mem_rd, drives ir_en=0 and pc_en=0, and stays in fetch.
- R3: Decode drives a_en, b_en and aluout_en with alu_a_sel=0, alu_b_sel=3 (sign-extended immediate shifted left by two) and ADD, whatever the opcode.
- R4: For opcode 0x00, execute drives aluout_en, alu_a_sel=1 (A) and alu_b_sel=0 (B). alu_op follows funct: 0x20→0 ADD, 0x22→1 SUB, 0x24→2 AND, 0x25→3 OR, 0x2A→4 SLT, 0x00→5 SLL, 0x02→6 SRL, 0x04→7 SLLV, 0x06→8 SRLV. The next cycle drives rf_we with rf_dst=1 (rd) and rf_src=0 (ALUOUT). The instruction takes four cycles.
- R5: Opcodes 0x08 (ADD), 0x0A (SLT), 0x0C (AND) and 0x0D (OR) execute with alu_a_sel=1, alu_b_sel=2 (immediate) and aluout_en. imm_zext=1 only for 0x0C and 0x0D. The next cycle writes back with rf_dst=0 (rt) and rf_src=0.
- R6: Load (0x23) executes an address ADD with alu_a_sel=1 and alu_b_sel=2. Its memory cycle drives mem_rd with addr_sel=1 (ALUOUT) and mdr_en when mem_wait is low. Write-back uses rf_dst=0 and rf_src=1 (MDR). The instruction takes five cycles.
- R7: Store (0x2B) executes the same address ADD. Its memory cycle drives mem_wr with addr_sel=1 and then returns to fetch. It never asserts rf_we.
- R8: While mem_wait is high in a load or store memory cycle, the sequencer repeats the same strobe and address select, keeps mdr_en at 0 and does not advance.
- R9: Branches 0x04 (taken when ab_equal=1) and 0x05 (taken when ab_equal=0) execute with alu_a_sel=1, alu_b_sel=0 and alu_op=1 (SUB) and pc_src=1 (ALUOUT). pc_en is high only when the branch is taken. The instruction then returns to fetch.
- R10: Jumps 0x02 and 0x03 execute with pc_en=1 and pc_src=2 (jump field). Opcode 0x03 also drives rf_we with rf_dst=2 (register 31) and rf_src=2 (PC).
- R11: Opcode 0x00 with funct 0x08 or 0x09 executes with pc_en=1 and pc_src=3 (A). Funct 0x09 also links with rf_we, rf_dst=2 and rf_src=2.
- R12: An unrecognised opcode, or opcode 0x00 with an unrecognised funct, returns to fetch straight after decode without asserting rf_we, mem_wr or pc_en.
- R13: Every control that a requirement does not name for a cycle is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction register bits 31:26 |
| funct | input | 6 | Instruction register bits 5:0 |
| ab_equal | input | 1 | Comparator result, A equals B |
| mem_wait | input | 1 | Memory not ready |
| pc_en | output | 1 | Load PC |
| ir_en | output | 1 | Load instruction register |
| a_en | output | 1 | Load A |
| b_en | output | 1 | Load B |
| aluout_en | output | 1 | Load ALU result register |
| mdr_en | output | 1 | Load memory data register |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALUOUT, 2 jump field, 3 A |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOUT |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel | output | 2 | ALU second operand: 0 B, 1 four, 2 immediate, 3 immediate times four |
| imm_zext | output | 1 | Zero-extend the immediate instead of sign-extending it |
| alu_op | output | 4 | ALU operation code |
| rf_we | output | 1 | Register-file write enable |
| rf_dst | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| rf_src | output | 2 | Write data: 0 ALUOUT, 1 MDR, 2 PC |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The assertions assume that opcode and funct stay steady from the start of a fetch until the instruction returns to fetch. In the real datapath they come from the instruction register, which changes only at the end of a fetch. The bench drives both fields at the start of each instruction's fetch and keeps them until the next one. The assertions also assume that mem_wait changes only at clock edges, so the bench drives it away from the edge. It inserts wait cycles in fetch and in both kinds of memory cycle, takes each branch both ways, and resets the sequencer partway through an instruction.

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       ab_equal,
  input  logic       mem_wait,
  output logic       pc_en,
  output logic       ir_en,
  output logic       a_en,
  output logic       b_en,
  output logic       aluout_en,
  output logic       mdr_en,
  output logic [1:0] pc_src,
  output logic       addr_sel,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic       imm_zext,
  output logic [3:0] alu_op,
  output logic       rf_we,
  output logic [1:0] rf_dst,
  output logic [1:0] rf_src,
  output logic       mem_rd,
  output logic       mem_wr
);
  localparam logic [5:0] OP_REG = 6'h00, OP_J = 6'h02, OP_JAL = 6'h03, OP_BEQ = 6'h04,
                         OP_BNE = 6'h05, OP_ADDI = 6'h08, OP_SLTI = 6'h0A, OP_ANDI = 6'h0C,
                         OP_ORI = 6'h0D, OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [5:0] FN_JR = 6'h08, FN_JALR = 6'h09;
  localparam logic [3:0] A_ADD = 4'd0, A_SUB = 4'd1, A_AND = 4'd2, A_OR = 4'd3, A_SLT = 4'd4,
                         A_SLL = 4'd5, A_SRL = 4'd6, A_SLLV = 4'd7, A_SRLV = 4'd8;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXR, S_EXI, S_EXADDR, S_MEMLD, S_MEMST,
    S_WBR, S_WBI, S_WBLD, S_EXBR, S_EXJ, S_EXJR
  } state_t;

  state_t st, nxt;
  logic       r_ok;
  logic [3:0] r_op;

  always_comb begin
    r_ok = 1'b1;
    case (funct)
      6'h20:   r_op = A_ADD;
      6'h22:   r_op = A_SUB;
      6'h24:   r_op = A_AND;
      6'h25:   r_op = A_OR;
      6'h2A:   r_op = A_SLT;
      6'h00:   r_op = A_SLL;
      6'h02:   r_op = A_SRL;
      6'h04:   r_op = A_SLLV;
      6'h06:   r_op = A_SRLV;
      default: begin r_op = A_ADD; r_ok = 1'b0; end
    endcase
  end

  always_ff @(posedge clk)
    if (rst) st <= S_FETCH;
    else     st <= nxt;

  always_comb begin
    nxt = st;
    {pc_en, ir_en, a_en, b_en, aluout_en, mdr_en} = '0;
    pc_src = 2'd0; addr_sel = 1'b0; alu_a_sel = 1'b0; alu_b_sel = 2'd0;
    imm_zext = 1'b0; alu_op = A_ADD;
    rf_we = 1'b0; rf_dst = 2'd0; rf_src = 2'd0;
    mem_rd = 1'b0; mem_wr = 1'b0;
    case (st)
      S_FETCH: begin
        mem_rd = 1'b1; alu_b_sel = 2'd1;
        if (!mem_wait) begin
          ir_en = 1'b1; pc_en = 1'b1; nxt = S_DECODE;
        end
      end
      S_DECODE: begin
        a_en = 1'b1; b_en = 1'b1; aluout_en = 1'b1; alu_b_sel = 2'd3;
        case (opcode)
          OP_REG:  nxt = r_ok ? S_EXR :
                         (funct == FN_JR || funct == FN_JALR) ? S_EXJR : S_FETCH;
          OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI: nxt = S_EXI;
          OP_LW, OP_SW:   nxt = S_EXADDR;
          OP_BEQ, OP_BNE: nxt = S_EXBR;
          OP_J, OP_JAL:   nxt = S_EXJ;
          default:        nxt = S_FETCH;
        endcase
      end
      S_EXR: begin
        aluout_en = 1'b1; alu_a_sel = 1'b1; alu_op = r_op; nxt = S_WBR;
      end
      S_EXI: begin
        aluout_en = 1'b1; alu_a_sel = 1'b1; alu_b_sel = 2'd2;
        imm_zext = (opcode == OP_ANDI) || (opcode == OP_ORI);
        case (opcode)
          OP_SLTI: alu_op = A_SLT;
          OP_ANDI: alu_op = A_AND;
          OP_ORI:  alu_op = A_OR;
          default: alu_op = A_ADD;
        endcase
        nxt = S_WBI;
      end
      S_EXADDR: begin
        aluout_en = 1'b1; alu_a_sel = 1'b1; alu_b_sel = 2'd2;
        nxt = (opcode == OP_LW) ? S_MEMLD : S_MEMST;
      end
      S_MEMLD: begin
        mem_rd = 1'b1; addr_sel = 1'b1;
        if (!mem_wait) begin mdr_en = 1'b1; nxt = S_WBLD; end
      end
      S_MEMST: begin
        mem_wr = 1'b1; addr_sel = 1'b1;
        if (!mem_wait) nxt = S_FETCH;
      end
      S_WBR:  begin rf_we = 1'b1; rf_dst = 2'd1; nxt = S_FETCH; end
      S_WBI:  begin rf_we = 1'b1; nxt = S_FETCH; end
      S_WBLD: begin rf_we = 1'b1; rf_src = 2'd1; nxt = S_FETCH; end
      S_EXBR: begin
        alu_a_sel = 1'b1; alu_op = A_SUB; pc_src = 2'd1;
        pc_en = ab_equal ^ (opcode == OP_BNE); nxt = S_FETCH;
      end
      S_EXJ: begin
        pc_en = 1'b1; pc_src = 2'd2;
        if (opcode == OP_JAL) begin rf_we = 1'b1; rf_dst = 2'd2; rf_src = 2'd2; end
        nxt = S_FETCH;
      end
      S_EXJR: begin
        pc_en = 1'b1; pc_src = 2'd3;
        if (funct == FN_JALR) begin rf_we = 1'b1; rf_dst = 2'd2; rf_src = 2'd2; end
        nxt = S_FETCH;
      end
      default: nxt = S_FETCH;
    endcase
  end

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> st == S_FETCH);

  // R2
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    ir_en |-> (mem_rd && !mem_wait && !addr_sel));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && mem_wait) |=> ($stable(mem_rd) && $stable(mem_wr) && $stable(addr_sel)));

  // R6
  mdr_load_chk: assert property (@(posedge clk) disable iff (rst)
    mdr_en |-> (mem_rd && addr_sel && !mem_wait));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9
  branch_after_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_en && pc_src == 2'd1) |-> $past(a_en && b_en && aluout_en));

  // R10
  link_src_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_dst == 2'd2) |-> (rf_src == 2'd2 && pc_en));
endmodule

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] opcode = '0, funct = '0;
  logic ab_equal = 1'b0, mem_wait = 1'b0;
  logic pc_en, ir_en, a_en, b_en, aluout_en, mdr_en, addr_sel, alu_a_sel, imm_zext;
  logic rf_we, mem_rd, mem_wr;
  logic [1:0] pc_src, alu_b_sel, rf_dst, rf_src;
  logic [3:0] alu_op;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  mc_seq_ctrl u_dut (.*);

  logic e_pc_en, e_ir_en, e_a_en, e_b_en, e_ao_en, e_mdr_en, e_addr, e_asel, e_zext;
  logic e_we, e_rd, e_wr;
  logic [1:0] e_pcsrc, e_bsel, e_dst, e_src;
  logic [3:0] e_op;

  task automatic clr();
    {e_pc_en, e_ir_en, e_a_en, e_b_en, e_ao_en, e_mdr_en, e_addr, e_asel, e_zext} = '0;
    {e_we, e_rd, e_wr} = '0;
    e_pcsrc = 0; e_bsel = 0; e_dst = 0; e_src = 0; e_op = 0;
  endtask

  task automatic step(input string tag, input bit w);
    logic [23:0] got, exp;
    mem_wait = w;
    #2;
    got = {pc_en, ir_en, a_en, b_en, aluout_en, mdr_en, pc_src, addr_sel, alu_a_sel,
           alu_b_sel, imm_zext, alu_op, rf_we, rf_dst, rf_src, mem_rd, mem_wr};
    exp = {e_pc_en, e_ir_en, e_a_en, e_b_en, e_ao_en, e_mdr_en, e_pcsrc, e_addr, e_asel,
           e_bsel, e_zext, e_op, e_we, e_dst, e_src, e_rd, e_wr};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%h fn=%h: controls got %h expected %h", tag, opcode, funct, got, exp);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch_exp(input bit go);
    clr(); e_rd = 1; e_bsel = 1; e_ir_en = go; e_pc_en = go;
  endtask

  function automatic int rop(input logic [5:0] fn);
    case (fn)
      6'h20: return 0; 6'h22: return 1; 6'h24: return 2; 6'h25: return 3;
      6'h2A: return 4; 6'h00: return 5; 6'h02: return 6; 6'h04: return 7;
      6'h06: return 8; default: return -1;
    endcase
  endfunction

  task automatic run(input logic [5:0] op, input logic [5:0] fn, input bit eq,
                     input int fw, input int mw);
    opcode = op; funct = fn; ab_equal = eq;
    for (int i = 0; i < fw; i++) begin fetch_exp(0); step("R2 fetch stall", 1); end
    fetch_exp(1); step("R2 fetch", 0);
    clr(); e_a_en = 1; e_b_en = 1; e_ao_en = 1; e_bsel = 3; step("R3 decode", 0);
    if (op == 6'h00 && rop(fn) >= 0) begin
      clr(); e_ao_en = 1; e_asel = 1; e_op = 4'(rop(fn)); step("R4 execute", 0);
      clr(); e_we = 1; e_dst = 1; step("R4 writeback", 0);
    end else if (op == 6'h00 && (fn == 6'h08 || fn == 6'h09)) begin
      clr(); e_pc_en = 1; e_pcsrc = 3;
      if (fn == 6'h09) begin e_we = 1; e_dst = 2; e_src = 2; end
      step("R11 register jump", 0);
    end else if (op == 6'h08 || op == 6'h0A || op == 6'h0C || op == 6'h0D) begin
      clr(); e_ao_en = 1; e_asel = 1; e_bsel = 2;
      e_zext = (op == 6'h0C || op == 6'h0D);
      e_op = (op == 6'h0A) ? 4 : (op == 6'h0C) ? 2 : (op == 6'h0D) ? 3 : 0;
      step("R5 execute", 0);
      clr(); e_we = 1; step("R5 writeback", 0);
    end else if (op == 6'h23 || op == 6'h2B) begin
      clr(); e_ao_en = 1; e_asel = 1; e_bsel = 2; step("R6 R7 address", 0);
      for (int i = 0; i < mw; i++) begin
        clr(); e_addr = 1; e_rd = (op == 6'h23); e_wr = (op == 6'h2B);
        step("R8 memory stall", 1);
      end
      clr(); e_addr = 1; e_rd = (op == 6'h23); e_wr = (op == 6'h2B); e_mdr_en = (op == 6'h23);
      step(op == 6'h23 ? "R6 memory read" : "R7 memory write", 0);
      if (op == 6'h23) begin clr(); e_we = 1; e_src = 1; step("R6 writeback", 0); end
    end else if (op == 6'h04 || op == 6'h05) begin
      clr(); e_asel = 1; e_op = 1; e_pcsrc = 1; e_pc_en = (op == 6'h04) ? eq : !eq;
      step("R9 branch", 0);
    end else if (op == 6'h02 || op == 6'h03) begin
      clr(); e_pc_en = 1; e_pcsrc = 2;
      if (op == 6'h03) begin e_we = 1; e_dst = 2; e_src = 2; end
      step("R10 jump", 0);
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    fetch_exp(1); step("R1 reset state", 0);
    rst = 1'b0;
    run(6'h00, 6'h20, 0, 0, 0);
    run(6'h00, 6'h22, 0, 2, 0);
    run(6'h00, 6'h24, 0, 0, 0);
    run(6'h00, 6'h25, 0, 0, 0);
    run(6'h00, 6'h2A, 0, 1, 0);
    run(6'h00, 6'h00, 0, 0, 0);
    run(6'h00, 6'h02, 0, 0, 0);
    run(6'h00, 6'h04, 0, 0, 0);
    run(6'h00, 6'h06, 0, 0, 0);
    run(6'h08, 6'h3F, 0, 0, 0);
    run(6'h0A, 6'h00, 0, 0, 0);
    run(6'h0C, 6'h00, 0, 0, 0);
    run(6'h0D, 6'h11, 0, 0, 0);
    run(6'h23, 6'h00, 0, 0, 0);
    run(6'h23, 6'h00, 0, 1, 3);
    run(6'h2B, 6'h00, 0, 0, 0);
    run(6'h2B, 6'h00, 0, 0, 2);
    run(6'h04, 6'h00, 1, 0, 0);
    run(6'h04, 6'h00, 0, 0, 0);
    run(6'h05, 6'h00, 1, 0, 0);
    run(6'h05, 6'h00, 0, 0, 0);
    run(6'h02, 6'h00, 0, 0, 0);
    run(6'h03, 6'h00, 0, 0, 0);
    run(6'h00, 6'h08, 0, 0, 0);
    run(6'h00, 6'h09, 0, 0, 0);
    // R12: unknown opcode and unknown funct drop back to fetch after decode
    run(6'h3F, 6'h00, 0, 0, 0);
    run(6'h00, 6'h3F, 0, 0, 0);
    run(6'h1A, 6'h00, 1, 0, 0);
    // R1: reset asserted partway through a load
    opcode = 6'h23;
    fetch_exp(1); step("R2 fetch", 0);
    rst = 1'b1;
    clr(); e_a_en = 1; e_b_en = 1; e_ao_en = 1; e_bsel = 3; step("R3 decode", 0);
    rst = 1'b0;
    fetch_exp(1); step("R1 fetch after reset", 0);
    clr(); e_a_en = 1; e_b_en = 1; e_ao_en = 1; e_bsel = 3; step("R13 decode", 0);
    clr(); e_ao_en = 1; e_asel = 1; e_bsel = 2; step("R6 address", 0);
    clr(); e_addr = 1; e_rd = 1; e_mdr_en = 1; step("R6 memory read", 0);
    clr(); e_we = 1; e_src = 1; step("R6 writeback", 0);
    run(6'h00, 6'h25, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule